// File: doc/BRIEF.md
# Panel Timing Generator with Power Sequencing

This block produces the raster timing for one LCD channel: a dot counter, a line counter, horizontal and vertical sync, and a display-enable strobe. The line length, the active width, the horizontal sync position and the horizontal sync width are given in units of eight dots. The frame height, the active height, the vertical sync line and its width are given in whole lines. Each pair of quantities arrives packed in one 32-bit word, low half and high half. The counters advance only on cycles where the dot-clock enable is high.

Software starts the channel with a start bit and then polls a two-bit power state until it reads 3. To stop the channel it clears the bit and polls until the state reads 0. The state moves one step after a fixed number of completed frames. While the channel is not fully powered, the syncs rest at their inactive level and display enable stays low. Software can also request a controller reset. A busy flag reports the reset, stays high for a fixed number of cycles and then clears by itself. While it is high, the counters and the power state are held at zero.

Top module: `panel_timing_gen`

## Requirements
- R1: The dot counter steps by one on each cycle with `dot_en` high and holds on each cycle with it low. After it reaches 8×HT−1 it returns to 0, where HT is `htiming_i[15:0]`.
- R2: The line counter steps by one each time the dot counter wraps. After it reaches VT−1 it returns to 0, where VT is `vtiming_i[15:0]`.
- R3: Display enable is high exactly when the dot count is below 8×`htiming_i[31:16]`, the line count is below `vtiming_i[31:16]`, and the power state is 3.
- R4: The horizontal sync window covers dot counts from 8×`hsync_i[15:0]` up to, but not including, 8×(`hsync_i[15:0]`+`hsync_i[31:16]`).
- R5: The vertical sync window covers whole lines from `vsync_i[15:0]` up to, but not including, `vsync_i[15:0]`+`vsync_i[31:16]`.
- R6: With `sync_pol_i[0]` set, horizontal sync is active low. With `sync_pol_i[1]` set, vertical sync is active low. With a bit clear, that sync is active high.
- R7: The power state is encoded as 0 off, 1 ramping and 3 on, and never takes the value 2. While `start_i` is high, the state moves 0→1 and then 1→3. Each step comes on the STEP_FRAMES-th frame end counted from the previous step, or from the moment the state left its target.
- R8: While `start_i` is low, the state moves 3→1 and then 1→0, with the same frame spacing as R7.
- R9: While the power state is not 3, both syncs sit at their inactive level and display enable is low.
- R10: A cycle with `soft_rst_req_i` high raises `rst_busy_o` at the next edge. The flag then stays high for exactly RESET_CYCLES cycles. Throughout, both counters read 0 and the power state reads 0. The dot counter first advances at the edge after the flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dot_en | input | 1 | Dot-clock enable |
| htiming_i | input | 32 | [15:0] line total / 8, [31:16] active width / 8 |
| hsync_i | input | 32 | [15:0] sync start / 8, [31:16] sync width / 8 |
| vtiming_i | input | 32 | [15:0] total lines, [31:16] active lines |
| vsync_i | input | 32 | [15:0] sync start line, [31:16] sync width in lines |
| sync_pol_i | input | 2 | bit 0 horizontal active low, bit 1 vertical active low |
| start_i | input | 1 | Start (1) or stop (0) request |
| soft_rst_req_i | input | 1 | Controller reset request |
| dot_x_o | output | 19 | Dot counter |
| line_y_o | output | 16 | Line counter |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| pwr_state_o | output | 2 | Power state (0, 1, 3) |
| rst_busy_o | output | 1 | Reset in progress |

## Verification
The assertions check several properties on every cycle. The counters hold whenever they are not told to advance, and a wrap always lands on zero. The power state never skips from off to on, never takes the code 2, and changes only at a frame end. While the reset flag is high, the counters and the power state are at zero, and the syncs are idle whenever the channel is not on. Only the bench scenarios can show the rest. These include the exact window positions in the raster, the frame count between power steps, the polarity inversion and the exact length of the reset flag. The bench sweeps every dot of complete frames and compares them against arithmetic expectations.

// File: rtl/ptg_pkg.sv
// Shared constants and types for the panel timing generator.
// Assumes every packed quantity word carries two fields of FIELD_W bits.
package ptg_pkg;
    localparam int FIELD_W   = 16;
    localparam int HSHIFT    = 3;   // horizontal quantities are in units of 8 dots
    localparam int POL_H_BIT = 0;
    localparam int POL_V_BIT = 1;

    typedef enum logic [1:0] {
        PWR_OFF  = 2'b00,
        PWR_RAMP = 2'b01,
        PWR_ON   = 2'b11
    } pwr_state_e;
endpackage

// File: rtl/ptg_axis_ctr.sv
// One raster axis: a position counter plus active and sync window decode.
// The programmed quantities are scaled by 2**SHIFT. A total of 0 acts as 1.
// A wrap happens when the counter advances from its last position.
module ptg_axis_ctr #(
    parameter int FW    = 16,
    parameter int SHIFT = 0,
    localparam int PW   = FW + SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [FW-1:0] total_u,
    input  logic [FW-1:0] active_u,
    input  logic [FW-1:0] sync_pos_u,
    input  logic [FW-1:0] sync_w_u,
    output logic [PW-1:0] pos_o,
    output logic          wrap_o,
    output logic          in_active_o,
    output logic          in_sync_o
);
    logic [PW-1:0] pos_q;
    logic [PW-1:0] total_s, active_s, spos_s, sw_s;
    logic          last;
    logic [PW:0]   sync_end;

    // Scale the programmed quantities into counter units.
    always_comb begin
        total_s  = PW'(total_u)    << SHIFT;
        active_s = PW'(active_u)   << SHIFT;
        spos_s   = PW'(sync_pos_u) << SHIFT;
        sw_s     = PW'(sync_w_u)   << SHIFT;
    end

    // Last position in the span, computed in a widened width so total 0 does not underflow.
    assign last = ({1'b0, pos_q} + (PW+1)'(1)) >= {1'b0, total_s};

    // Position register: clear, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         pos_q <= '0;
        else if (clr)       pos_q <= '0;
        else if (adv)       pos_q <= last ? '0 : pos_q + PW'(1);
    end

    // Window decode for active area and sync pulse.
    always_comb begin
        sync_end    = {1'b0, spos_s} + {1'b0, sw_s};
        in_active_o = pos_q < active_s;
        in_sync_o   = (pos_q >= spos_s) && ({1'b0, pos_q} < sync_end);
    end

    assign wrap_o = adv && last && !clr;
    assign pos_o  = pos_q;

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(pos_q)); // R1
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (pos_q == '0)); // R2
endmodule

// File: rtl/ptg_power_seq.sv
// Power-state sequencer: it moves one step toward the target on the
// STEP_FRAMES-th frame end. The target is on while start is high and off
// while it is low. The frame counter clears whenever the state is at its target.
module ptg_power_seq
    import ptg_pkg::*;
#(
    parameter int STEP_FRAMES = 4,
    localparam int SCW = $clog2(STEP_FRAMES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       start,
    input  logic       frame_end,
    output pwr_state_e state_o
);
    pwr_state_e     state_q, next_state;
    logic [SCW-1:0] cnt_q;
    logic           at_target;

    // Target check and next step in the current direction.
    always_comb begin
        at_target  = start ? (state_q == PWR_ON) : (state_q == PWR_OFF);
        next_state = state_q;
        case (state_q)
            PWR_OFF:  next_state = start ? PWR_RAMP : PWR_OFF;
            PWR_RAMP: next_state = start ? PWR_ON   : PWR_OFF;
            PWR_ON:   next_state = start ? PWR_ON   : PWR_RAMP;
            default:  next_state = PWR_OFF;
        endcase
    end

    // Frame counting and state stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q <= PWR_OFF;
            cnt_q   <= '0;
        end else if (at_target) begin
            cnt_q   <= '0;
        end else if (frame_end) begin
            if (cnt_q == SCW'(STEP_FRAMES - 1)) begin
                cnt_q   <= '0;
                state_q <= next_state;
            end else begin
                cnt_q   <= cnt_q + SCW'(1);
            end
        end
    end

    assign state_o = state_q;

    AST_PWR_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_end && !clr) |=> $stable(state_q)); // R7
    AST_PWR_NO_JUMP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_OFF) |=> (state_q != PWR_ON)); // R7
    AST_PWR_NO_JUMP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_ON && !clr) |=> (state_q != PWR_OFF)); // R8
    AST_PWR_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != 2'b10)); // R7
endmodule

// File: rtl/ptg_soft_reset.sv
// Self-clearing controller reset: a request raises busy, which stays high
// for RESET_CYCLES cycles. A request during busy restarts the count.
module ptg_soft_reset #(
    parameter int RESET_CYCLES = 16,
    localparam int RCW = $clog2(RESET_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy_o
);
    logic           busy_q;
    logic [RCW-1:0] cnt_q;

    // Busy flag and its duration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (req) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == RCW'(RESET_CYCLES - 1)) busy_q <= 1'b0;
            else                                 cnt_q  <= cnt_q + RCW'(1);
        end
    end

    assign busy_o = busy_q;

    AST_REQ_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> busy_q); // R10
endmodule

// File: rtl/panel_timing_gen.sv
// Top of the panel timing generator for one channel. It unpacks the quantity
// words, drives two axis counters, and gates the syncs and enable with the
// power state. Assumes the configuration words are held stable while the channel runs.
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter int STEP_FRAMES  = 4,
    parameter int RESET_CYCLES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dot_en,
    input  logic [2*FIELD_W-1:0]    htiming_i,
    input  logic [2*FIELD_W-1:0]    hsync_i,
    input  logic [2*FIELD_W-1:0]    vtiming_i,
    input  logic [2*FIELD_W-1:0]    vsync_i,
    input  logic [1:0]              sync_pol_i,
    input  logic                    start_i,
    input  logic                    soft_rst_req_i,
    output logic [FIELD_W+HSHIFT-1:0] dot_x_o,
    output logic [FIELD_W-1:0]      line_y_o,
    output logic                    hsync_o,
    output logic                    vsync_o,
    output logic                    de_o,
    output logic [1:0]              pwr_state_o,
    output logic                    rst_busy_o
);
    logic       busy, clr;
    logic       line_step, frame_end;
    logic       h_act, h_syn, v_act, v_syn;
    logic       on;
    pwr_state_e pwr;

    ptg_soft_reset #(.RESET_CYCLES(RESET_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .req(soft_rst_req_i), .busy_o(busy)
    );

    assign clr = soft_rst_req_i | busy;

    ptg_axis_ctr #(.FW(FIELD_W), .SHIFT(HSHIFT)) u_h (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(dot_en),
        .total_u(htiming_i[FIELD_W-1:0]),  .active_u(htiming_i[2*FIELD_W-1:FIELD_W]),
        .sync_pos_u(hsync_i[FIELD_W-1:0]), .sync_w_u(hsync_i[2*FIELD_W-1:FIELD_W]),
        .pos_o(dot_x_o), .wrap_o(line_step), .in_active_o(h_act), .in_sync_o(h_syn)
    );

    ptg_axis_ctr #(.FW(FIELD_W), .SHIFT(0)) u_v (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(line_step),
        .total_u(vtiming_i[FIELD_W-1:0]),  .active_u(vtiming_i[2*FIELD_W-1:FIELD_W]),
        .sync_pos_u(vsync_i[FIELD_W-1:0]), .sync_w_u(vsync_i[2*FIELD_W-1:FIELD_W]),
        .pos_o(line_y_o), .wrap_o(frame_end), .in_active_o(v_act), .in_sync_o(v_syn)
    );

    ptg_power_seq #(.STEP_FRAMES(STEP_FRAMES)) u_pwr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(start_i),
        .frame_end(frame_end), .state_o(pwr)
    );

    // Output gating: the syncs and enable are live only when fully powered, then polarity is applied.
    always_comb begin
        on          = (pwr == PWR_ON);
        de_o        = h_act && v_act && on;
        hsync_o     = (h_syn && on) ^ sync_pol_i[POL_H_BIT];
        vsync_o     = (v_syn && on) ^ sync_pol_i[POL_V_BIT];
        pwr_state_o = pwr;
        rst_busy_o  = busy;
    end

    AST_BUSY_COUNTERS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy_o |-> (dot_x_o == '0 && line_y_o == '0)); // R10
    AST_BUSY_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy_o |-> (pwr_state_o == 2'b00)); // R10
    AST_SYNC_IDLE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state_o != 2'b11) |-> (!de_o && hsync_o == sync_pol_i[0] && vsync_o == sync_pol_i[1])); // R9
endmodule

// File: tb/panel_timing_gen_tb.sv
module panel_timing_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STEP = 2;
    localparam int RSTC = 4;
    localparam int HT = 4, HA = 2, HSP = 3, HSW = 1;
    localparam int VT = 6, VA = 4, VSP = 4, VSW = 1;
    localparam int LW = 8 * HT;
    localparam int FL = LW * VT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dot_en = 1'b0;
    logic [31:0] htiming, hsync, vtiming, vsync;
    logic [1:0]  pol = 2'b00;
    logic        start = 1'b0;
    logic        srst = 1'b0;
    logic [18:0] dot_x;
    logic [15:0] line_y;
    logic        hs, vs, de, busy;
    logic [1:0]  pwr;

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign htiming = {16'(HA), 16'(HT)};
    assign hsync   = {16'(HSW), 16'(HSP)};
    assign vtiming = {16'(VA), 16'(VT)};
    assign vsync   = {16'(VSW), 16'(VSP)};

    panel_timing_gen #(.STEP_FRAMES(STEP), .RESET_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en),
        .htiming_i(htiming), .hsync_i(hsync), .vtiming_i(vtiming), .vsync_i(vsync),
        .sync_pol_i(pol), .start_i(start), .soft_rst_req_i(srst),
        .dot_x_o(dot_x), .line_y_o(line_y), .hsync_o(hs), .vsync_o(vs), .de_o(de),
        .pwr_state_o(pwr), .rst_busy_o(busy)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d n=%0d", req, act, exp, n);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (dot_en) n++;
        @(negedge clk);
    endtask

    // Full raster comparison against arithmetic expectations for the given power state.
    task automatic check_raster(int exp_pwr);
        int ex, ey;
        bit on;
        ex = n % LW;
        ey = (n / LW) % VT;
        on = (exp_pwr == 3);
        check("R1 dot", int'(dot_x), ex);
        check("R2 line", int'(line_y), ey);
        check("R7/R8 pwr", int'(pwr), exp_pwr);
        check("R3/R9 de", int'(de), int'(on && ex < 8*HA && ey < VA));
        check("R4/R6/R9 hsync", int'(hs),
              int'((on && ex >= 8*HSP && ex < 8*(HSP+HSW)) ^ pol[0]));
        check("R5/R6/R9 vsync", int'(vs),
              int'((on && ey >= VSP && ey < VSP+VSW) ^ pol[1]));
    endtask

    function automatic int up_state(int k);
        return (k < STEP) ? 0 : (k < 2*STEP) ? 1 : 3;
    endfunction
    function automatic int down_state(int k);
        return (k < STEP) ? 3 : (k < 2*STEP) ? 1 : 0;
    endfunction

    task automatic soft_reset();
        srst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        srst = 1'b0;
        for (int i = 0; i < RSTC; i++) begin
            check("R10 busy high", int'(busy), 1);
            check("R10 dot zero", int'(dot_x), 0);
            check("R10 pwr zero", int'(pwr), 0);
            @(posedge clk);
            @(negedge clk);
        end
        check("R10 busy cleared", int'(busy), 0);
        check("R10 dot zero at release", int'(dot_x), 0);
        n = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0, k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        check("R10 reset busy", int'(busy), 0);
        check("R7 reset pwr", int'(pwr), 0);
        check("R1 reset dot", int'(dot_x), 0);
        check("R2 reset line", int'(line_y), 0);
        check("R9 reset de", int'(de), 0);
        check("R9 reset hsync", int'(hs), 0);

        // Controller reset with the dot enable running
        dot_en = 1'b1;
        soft_reset();

        // Start: power ramps up, raster checked on every dot
        start = 1'b1;
        n0 = n;
        for (int i = 0; i < 5*FL; i++) begin
            tick();
            k = n / FL - n0 / FL;
            check_raster(up_state(k));
        end

        // Powered sweep with active-high syncs
        for (int i = 0; i < 2*FL; i++) begin
            tick();
            check_raster(3);
        end

        // Active-low syncs, gapped dot enable (R1 hold)
        pol = 2'b11;
        for (int i = 0; i < 4*FL; i++) begin
            dot_en = (i % 3) != 1;
            tick();
            check_raster(3);
        end
        dot_en = 1'b1;

        // Stop: power ramps down
        start = 1'b0;
        n0 = n;
        for (int i = 0; i < 5*FL; i++) begin
            tick();
            k = n / FL - n0 / FL;
            check_raster(down_state(k));
        end

        // Reset while powered forces the state back to off
        pol = 2'b00;
        start = 1'b1;
        n0 = n;
        for (int i = 0; i < 5*FL; i++) begin
            tick();
            k = n / FL - n0 / FL;
            check_raster(up_state(k));
        end
        soft_reset();
        start = 1'b0;
        tick();
        check_raster(0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule